// File: doc/BRIEF.md
# Strobe-Snooping Capture Ring with Remote Read-Index Mirror

This block listens to an active-low I/O chip-select strobe that another processor drives, and each time that strobe falls it records the byte on the shared data bus into a local 256-slot circular store. Software takes no part in the capture. The strobe is asynchronous to the block clock, so it passes through a two-flop synchroniser with edge detection. The data bus is sampled one clock after the synchronised falling edge.

A local consumer takes bytes out one at a time with a pop request. A pop on an empty store returns a "no data" answer. A remote ring in the producer's memory may be attached. In that case every successful pop writes the new consume count through a simple bus-master port to the remote read-index location at base−1, so the producer can see the space that has been freed.

An initialise command attaches the remote ring. It reads the remote write index at base−2, copies that value into the remote read index at base−1, and only then records the base. While a master access is running the block reports busy and ignores new pop and initialise requests.

Top module: `snoop_capture_ring`

## Requirements
- R1: A falling edge on `strobe_n` stores the value of `bus_data` into the next slot. Popping returns the stored bytes in the order they were captured.
- R2: The store has 256 slots and its indices wrap. The consume count written back goes from 255 to 0.
- R3: A pop on an empty store returns `pop_hit`=0 and `pop_data`=8'hFF. It does not change the consume count and starts no master access.
- R4: `pop_done` is high for the cycle after the cycle in which an accepted `pop_req` was seen. `pop_hit` and `pop_data` are valid in that same cycle.
- R5: When the remote base is non-zero, each successful pop makes one write (`mst_we`=1) to address base−1, carrying the consume count after the increment.
- R6: While the remote base is zero, pops make no master access.
- R7: `init_req` with `init_base` first reads base−2, then writes the value it read to base−1, and only after that uses the new base for later pops.
- R8: After reset the consume count is 0, the remote base is 0, `overflow` is 0, and `busy`, `mst_req` and `pop_done` are all low.
- R9: A capture that would make the capture index equal to the consume index is dropped, so at most 255 bytes are held. The drop sets `overflow`, which stays set until reset.
- R10: `mst_req` together with its address and direction stays steady until `mst_ack`. While `busy` is high, `pop_req` and `init_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | Asynchronous active-low I/O chip-select being snooped |
| bus_data | input | DATA_W | Snooped data bus |
| pop_req | input | 1 | Consumer pop request |
| pop_done | output | 1 | Pop answer valid |
| pop_hit | output | 1 | 1 when the pop returned a byte, 0 when the store was empty |
| pop_data | output | DATA_W | Popped byte, all ones when empty |
| init_req | input | 1 | Attach the remote ring at init_base |
| init_base | input | ADDR_W | Remote ring base address |
| busy | output | 1 | A master access sequence is in progress |
| overflow | output | 1 | Sticky lost-capture flag |
| mst_req | output | 1 | Master bus request, held until ack |
| mst_we | output | 1 | 1 for a write, 0 for a read |
| mst_addr | output | ADDR_W | Master address |
| mst_wdata | output | DATA_W | Master write data |
| mst_rdata | input | DATA_W | Master read data, valid with ack |
| mst_ack | input | 1 | Master access complete |

## Verification
A strobe that falls just after a negative edge is stored on the third rising edge after that fall: two synchroniser stages, then the capture register. The strobe task holds the data for five clocks and waits four more before it returns, so every check reads a completed capture. A pop answer appears one rising edge after the request and is sampled on the following falling edge. Write-back and initialisation results depend on the responder's ack delay, so the bench waits for `busy` to drop and then compares the responder's log of master accesses with the expected addresses, data and order.

// File: rtl/snoop_capture_ring.sv
module snoop_capture_ring #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              pop_req,
  output logic              pop_done,
  output logic              pop_hit,
  output logic [DATA_W-1:0] pop_data,
  input  logic              init_req,
  input  logic [ADDR_W-1:0] init_base,
  output logic              busy,
  output logic              overflow,
  output logic              mst_req,
  output logic              mst_we,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  input  logic [DATA_W-1:0] mst_rdata,
  input  logic              mst_ack
);
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_INIT_RD, S_INIT_WR} state_t;

  state_t             st;
  logic [2:0]         cs_sync;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic [ADDR_W-1:0]  base, pend_base;
  logic [DATA_W-1:0]  init_val;
  logic [DATA_W-1:0]  mem [DEPTH];

  wire cs_fall  = cs_sync[2] & ~cs_sync[1];
  wire full     = (wr_idx + IDX_W'(1)) == rd_idx;
  wire has_data = wr_idx != rd_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cs_sync <= '1;
    else        cs_sync <= {cs_sync[1:0], strobe_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_idx   <= '0;
      overflow <= 1'b0;
    end else if (cs_fall) begin
      if (full) overflow <= 1'b1;
      else      wr_idx   <= wr_idx + IDX_W'(1);
    end

  always_ff @(posedge clk)
    if (cs_fall && !full) mem[wr_idx] <= bus_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_idx    <= '0;
      base      <= '0;
      pend_base <= '0;
      init_val  <= '0;
      pop_done  <= 1'b0;
      pop_hit   <= 1'b0;
      pop_data  <= '0;
    end else begin
      pop_done <= 1'b0;
      unique case (st)
        S_IDLE:
          if (pop_req) begin
            pop_done <= 1'b1;
            pop_hit  <= has_data;
            if (has_data) begin
              pop_data <= mem[rd_idx];
              rd_idx   <= rd_idx + IDX_W'(1);
              if (base != '0) st <= S_WB;
            end else begin
              pop_data <= '1;
            end
          end else if (init_req) begin
            pend_base <= init_base;
            st        <= S_INIT_RD;
          end
        S_WB:
          if (mst_ack) st <= S_IDLE;
        S_INIT_RD:
          if (mst_ack) begin
            init_val <= mst_rdata;
            st       <= S_INIT_WR;
          end
        S_INIT_WR:
          if (mst_ack) begin
            base <= pend_base;
            st   <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end

  assign busy      = st != S_IDLE;
  assign mst_req   = busy;
  assign mst_we    = st != S_INIT_RD;
  assign mst_addr  = (st == S_WB)      ? base - ADDR_W'(1) :
                     (st == S_INIT_RD) ? pend_base - ADDR_W'(2) :
                                         pend_base - ADDR_W'(1);
  assign mst_wdata = (st == S_INIT_WR) ? init_val : DATA_W'(rd_idx);
endmodule

// File: rtl/snoop_capture_ring_chk.sv
module snoop_capture_ring_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pop_req,
  input logic              pop_done,
  input logic              pop_hit,
  input logic              overflow,
  input logic              mst_req,
  input logic              mst_we,
  input logic [ADDR_W-1:0] mst_addr,
  input logic              mst_ack
);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mst_req && !mst_ack |=> mst_req && $stable(mst_addr) && $stable(mst_we));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_pop_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |-> $past(pop_req));

  assert_empty_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done && !pop_hit |-> !mst_req);

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !overflow && !mst_req && !pop_done);
endmodule

bind snoop_capture_ring snoop_capture_ring_chk i_chk (.*);

// File: tb/test_snoop_capture_ring.sv
module test_snoop_capture_ring;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe_n = 1'b1;
  logic [7:0]  bus_data = '0;
  logic        pop_req = 1'b0;
  logic        pop_done, pop_hit, busy, overflow;
  logic [7:0]  pop_data;
  logic        init_req = 1'b0;
  logic [15:0] init_base = '0;
  logic        mst_req, mst_we;
  logic [15:0] mst_addr;
  logic [7:0]  mst_wdata, mst_rdata;
  logic        mst_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  int acc_cnt = 0, resp_cnt = 0;
  logic [7:0]  remote [256];
  logic [15:0] log_addr [16];
  logic        log_we [16];
  logic [7:0]  log_data [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_capture_ring i_snoop_capture_ring (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .bus_data(bus_data),
    .pop_req(pop_req), .pop_done(pop_done), .pop_hit(pop_hit), .pop_data(pop_data),
    .init_req(init_req), .init_base(init_base), .busy(busy), .overflow(overflow),
    .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_rdata(mst_rdata), .mst_ack(mst_ack));

  assign mst_rdata = remote[mst_addr[7:0]];

  always @(negedge clk) begin
    if (mst_ack) begin
      mst_ack  <= 1'b0;
      resp_cnt <= 0;
    end else if (mst_req) begin
      if (resp_cnt == 2) begin
        mst_ack <= 1'b1;
        log_addr[acc_cnt % 16] <= mst_addr;
        log_we[acc_cnt % 16]   <= mst_we;
        log_data[acc_cnt % 16] <= mst_we ? mst_wdata : mst_rdata;
        if (mst_we) remote[mst_addr[7:0]] <= mst_wdata;
        acc_cnt <= acc_cnt + 1;
      end else resp_cnt <= resp_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic capture(input logic [7:0] b);
    @(negedge clk);
    bus_data = b;
    strobe_n = 1'b0;
    repeat (5) @(negedge clk);
    strobe_n = 1'b1;
    bus_data = ~b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop(output logic hit, output logic [7:0] data, output logic done);
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    done = pop_done;
    hit  = pop_hit;
    data = pop_data;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset;
    logic h, d; logic [7:0] v;
    check(!overflow && !busy && !mst_req && !pop_done, "R8 reset outputs", {overflow, busy, mst_req, pop_done}, 0);
    pop(h, v, d);
    check(d && !h && v == 8'hFF, "R3 empty pop", {d, h, v}, {1'b1, 1'b0, 8'hFF});
    check(acc_cnt == 0, "R6 no access with zero base", acc_cnt, 0);
  endtask

  task automatic t_order;
    logic h, d; logic [7:0] v;
    logic [7:0] pat [3] = '{8'hA5, 8'h3C, 8'h0F};
    for (int i = 0; i < 3; i++) capture(pat[i]);
    for (int i = 0; i < 3; i++) begin
      pop(h, v, d);
      check(d && h && v == pat[i], "R1 R4 capture order", v, pat[i]);
    end
    check(acc_cnt == 0, "R6 no write-back with zero base", acc_cnt, 0);
  endtask

  task automatic t_init;
    int a0 = acc_cnt;
    remote[8'hFE] = 8'h37;
    remote[8'hFF] = 8'h00;
    @(negedge clk);
    init_req = 1'b1;
    init_base = 16'h1000;
    @(negedge clk);
    init_req = 1'b0;
    check(busy, "R7 busy during init", busy, 1);
    while (busy) @(negedge clk);
    check(acc_cnt == a0 + 2, "R7 two accesses", acc_cnt - a0, 2);
    check(!log_we[a0 % 16] && log_addr[a0 % 16] == 16'h0FFE, "R7 read of write index first",
          {log_we[a0 % 16], log_addr[a0 % 16]}, 16'h0FFE);
    check(log_we[(a0+1) % 16] && log_addr[(a0+1) % 16] == 16'h0FFF && remote[8'hFF] == 8'h37,
          "R7 copy to read index", remote[8'hFF], 8'h37);
  endtask

  task automatic t_writeback;
    int a0;
    logic h, d; logic [7:0] v;
    capture(8'h81);
    capture(8'h82);
    a0 = acc_cnt;
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    check(pop_done && pop_hit && pop_data == 8'h81, "R4 first pop", pop_data, 8'h81);
    @(negedge clk);
    pop_req = 1'b0;
    check(!pop_done, "R10 pop ignored while busy", pop_done, 0);
    while (busy) @(negedge clk);
    check(acc_cnt == a0 + 1 && log_we[a0 % 16] && log_addr[a0 % 16] == 16'h0FFF && log_data[a0 % 16] == 8'd4,
          "R5 write-back of count", log_data[a0 % 16], 4);
    pop(h, v, d);
    check(h && v == 8'h82, "R10 second byte not skipped", v, 8'h82);
    check(remote[8'hFF] == 8'd5, "R5 count after second pop", remote[8'hFF], 5);
  endtask

  task automatic t_wrap;
    logic h, d; logic [7:0] v;
    for (int i = 0; i < 260; i++) begin
      capture(8'(i * 7 + 1));
      pop(h, v, d);
      check(h && v == 8'(i * 7 + 1), "R2 data across wrap", v, 8'(i * 7 + 1));
      check(remote[8'hFF] == 8'(6 + i), "R2 R5 wrapped count", remote[8'hFF], 8'(6 + i));
    end
  endtask

  task automatic t_overflow;
    logic h, d; logic [7:0] v;
    for (int i = 0; i < 255; i++) capture(8'(i) ^ 8'h5A);
    check(!overflow, "R9 no overflow at 255", overflow, 0);
    capture(8'hEE);
    check(overflow, "R9 overflow on 256th", overflow, 1);
    for (int i = 0; i < 255; i++) begin
      pop(h, v, d);
      check(h && v == (8'(i) ^ 8'h5A), "R9 held bytes intact", v, 8'(i) ^ 8'h5A);
    end
    pop(h, v, d);
    check(!h && v == 8'hFF, "R3 R9 dropped byte absent", {h, v}, 8'hFF);
    check(overflow, "R9 flag sticky", overflow, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_init();
    t_writeback();
    t_wrap();
    t_overflow();
    report();
  end
endmodule